// File: doc/BRIEF.md
# Serial-In Latched Parallel Driver Core

This block is the logic core of an eight-channel driver that is loaded one bit at a time. On each rising clock edge the serial input enters the first stage of a shift register, and the rest of the register moves one stage on. The last stage is driven out as a serial output, so several devices can be chained. The chain shares one clock, and each device passes its oldest bit to the next.

A storage stage sits between the shift register and the outputs. While the strobe input is high, the storage stage is transparent: it shows the register contents, and that includes bits that arrive while the strobe stays high. When the strobe goes low, the storage stage keeps the value it held last. An active-low output enable passes the stored word to the parallel outputs. When the enable is high, every output is driven low, never left floating. A synchronous active-low reset clears both the register and the storage stage.

The strobe and the serial input are treated as synchronous to the clock. For a new word to stay in storage after the strobe falls, the strobe must be high across at least one rising clock edge. The output enable, and the transparent path opened by the strobe, act on the outputs at once.

Top module: `latched_serial_driver`

## Requirements
- R1: When rst_n is low at a rising clock edge, the shift register and the storage stage both become all zeros. After that edge, ser_out is 0, and drv_out is 0 whatever the values of strobe and oe_n.
- R2: At each rising clock edge with rst_n high, stage 0 takes ser_in and every stage k > 0 takes the previous value of stage k-1. After eight edges, the first bit shifted in is in stage 7 and the last one is in stage 0. Stage k drives drv_out[k].
- R3: ser_out always equals the last stage (stage 7) and changes only at a rising clock edge. Changes on ser_in between edges never reach it.
- R4: While strobe is high, the stored word follows the shift register. This holds immediately when strobe rises and after every edge that shifts in a new bit.
- R5: While strobe is low, the stored word keeps the value present when strobe fell, whatever happens on the clock and on ser_in. To be kept, a word needs strobe to be high across at least one rising edge.
- R6: While oe_n is low, drv_out[k] equals bit k of the stored word.
- R7: While oe_n is high, drv_out is all zeros, whatever the stored word or strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift and capture clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset of register and storage |
| ser_in | input | 1 | Serial data into stage 0 |
| strobe | input | 1 | High makes the storage stage transparent |
| oe_n | input | 1 | Active-low output enable |
| ser_out | output | 1 | Last register stage, for chaining devices |
| drv_out | output | 8 | Parallel outputs, stage k on bit k |

## Verification
Shifting and storage transfer can fall in the same cycle. This is provoked by holding strobe high while new bits are clocked in, and also by raising strobe for a single edge that also shifts a bit. The outputs must then show the word after the shift, and they must keep exactly that word once strobe drops. Output gating is also exercised while the stored word is changing. With oe_n high, the outputs must stay all zeros during the transparent loading. When oe_n is released, the outputs must show the word that is stored at that moment.

// File: rtl/lsd_pkg.sv
`timescale 1ns/1ps
// Package lsd_pkg: shared width settings for the serial-in latched driver.
// Assumes every block in the driver uses the same channel count.
package lsd_pkg;
    parameter int unsigned LSD_CHANNELS = 8;
    typedef logic [LSD_CHANNELS-1:0] lsd_word_t;
endpackage

// File: rtl/lsd_shift_stage.sv
`timescale 1ns/1ps
// Module lsd_shift_stage: serial-in shift register. Stage 0 takes din on each
// rising edge and each higher stage takes its lower neighbour. It also gives
// out the value the register will take at the coming edge, for the storage stage.
// Assumes din is stable around the rising edge. The reset is synchronous and active low.
module lsd_shift_stage #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    output logic [WIDTH-1:0] shift_q,
    output logic [WIDTH-1:0] shift_next
);
    // Purpose: form the word that follows the coming shift.
    always_comb begin
        shift_next = {shift_q[WIDTH-2:0], din};
    end

    // Purpose: advance the register, or clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else begin
            shift_q <= shift_next;
        end
    end
endmodule

// File: rtl/lsd_hold_stage.sv
`timescale 1ns/1ps
// Module lsd_hold_stage: storage stage modelled in the clock domain. While
// strobe is high, the visible word is the live shift register, and each edge
// records the shifted word. While strobe is low, the recorded word is shown.
// Assumes strobe is synchronous and high across at least one edge per capture.
module lsd_hold_stage #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic [WIDTH-1:0] shift_q,
    input  logic [WIDTH-1:0] shift_next,
    output logic [WIDTH-1:0] hold_q,
    output logic [WIDTH-1:0] view
);
    // Purpose: record the post-shift word while transparent, else keep it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (strobe) begin
            hold_q <= shift_next;
        end
    end

    // Purpose: show the live register while transparent, the record otherwise.
    always_comb begin
        view = strobe ? shift_q : hold_q;
    end
endmodule

// File: rtl/lsd_out_gate.sv
`timescale 1ns/1ps
// Module lsd_out_gate: per-channel output gating. Each channel passes its
// stored bit while oe_n is low and is driven low while oe_n is high.
// Assumes the outputs are never tristated.
module lsd_out_gate #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             oe_n,
    input  logic [WIDTH-1:0] word,
    output logic [WIDTH-1:0] drv
);
    for (genvar ch = 0; ch < WIDTH; ch++) begin : g_chan
        // Purpose: gate one channel with the shared enable.
        always_comb begin
            drv[ch] = word[ch] & ~oe_n;
        end
    end
endmodule

// File: rtl/latched_serial_driver.sv
`timescale 1ns/1ps
// Module latched_serial_driver: top of the serial-in latched driver core.
// It chains the shift register, the storage stage and the output gating, and
// brings the last register stage out for chaining devices.
// Assumes all inputs are synchronous to clk. The reset is synchronous and active low.
module latched_serial_driver
    import lsd_pkg::*;
#(
    parameter int unsigned WIDTH = LSD_CHANNELS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_in,
    input  logic             strobe,
    input  logic             oe_n,
    output logic             ser_out,
    output logic [WIDTH-1:0] drv_out
);
    localparam int unsigned LAST = WIDTH - 1;

    logic [WIDTH-1:0] shift_q;
    logic [WIDTH-1:0] shift_next;
    logic [WIDTH-1:0] hold_q;
    logic [WIDTH-1:0] view;

    lsd_shift_stage #(.WIDTH(WIDTH)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .din        (ser_in),
        .shift_q    (shift_q),
        .shift_next (shift_next)
    );

    lsd_hold_stage #(.WIDTH(WIDTH)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (strobe),
        .shift_q    (shift_q),
        .shift_next (shift_next),
        .hold_q     (hold_q),
        .view       (view)
    );

    lsd_out_gate #(.WIDTH(WIDTH)) u_gate (
        .oe_n (oe_n),
        .word (view),
        .drv  (drv_out)
    );

    // Purpose: present the last register stage for the next device in the chain.
    always_comb begin
        ser_out = shift_q[LAST];
    end
endmodule

// File: rtl/latched_serial_driver_chk.sv
`timescale 1ns/1ps
// Module latched_serial_driver_chk: property checker bound to the driver top.
// It watches the ports and the stage outputs. It assumes WIDTH is at least 2.
module latched_serial_driver_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ser_in,
    input logic             strobe,
    input logic             oe_n,
    input logic             ser_out,
    input logic [WIDTH-1:0] drv_out,
    input logic [WIDTH-1:0] shift_q,
    input logic [WIDTH-1:0] hold_q,
    input logic [WIDTH-1:0] view
);
    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (ser_out == 1'b0 && hold_q == '0)); // R1
    AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) rst_n |=> (shift_q[0] == $past(ser_in) && shift_q[WIDTH-1:1] == $past(shift_q[WIDTH-2:0]))); // R2
    AST_SEROUT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n) rst_n |=> ser_out == $past(shift_q[WIDTH-2])); // R3
    AST_TRANSPARENT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n) (rst_n && strobe) |=> hold_q == shift_q); // R4
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (rst_n && !strobe) |=> $stable(hold_q)); // R5
    AST_ENABLED_PASS: assert property (@(posedge clk) disable iff (!rst_n) !oe_n |-> drv_out == view); // R6
    AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n) oe_n |-> drv_out == '0); // R7
endmodule

bind latched_serial_driver latched_serial_driver_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ser_in  (ser_in),
    .strobe  (strobe),
    .oe_n    (oe_n),
    .ser_out (ser_out),
    .drv_out (drv_out),
    .shift_q (shift_q),
    .hold_q  (hold_q),
    .view    (view)
);

// File: tb/latched_serial_driver_tb_top.sv
`timescale 1ns/1ps
// Bench latched_serial_driver_tb_top: directed tests for the driver core.
// Inputs change 1 ns after a rising edge. That leaves 4 ns of setup and 1 ns
// of hold, the same ratio as the required timing scaled to the 5 ns clock.
module latched_serial_driver_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_in = 1'b0;
    logic       strobe = 1'b0;
    logic       oe_n = 1'b0;
    logic       ser_out;
    logic [7:0] drv_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] m_sr  = '0;
    logic [7:0] m_lat = '0;

    latched_serial_driver #(.WIDTH(8)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ser_in  (ser_in),
        .strobe  (strobe),
        .oe_n    (oe_n),
        .ser_out (ser_out),
        .drv_out (drv_out)
    );

    always #2.5 clk = ~clk;

    function automatic logic [7:0] exp_drv();
        if (oe_n) return 8'h00;
        return strobe ? m_sr : m_lat;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(input string req);
        check(req, drv_out, exp_drv());
        check(req, {7'd0, ser_out}, {7'd0, m_sr[7]});
    endtask

    // One rising edge carrying bit b; the model follows the requirements.
    task automatic step(input logic b);
        ser_in = b;
        @(posedge clk);
        if (!rst_n) begin
            m_sr = '0;
            m_lat = '0;
        end else begin
            m_sr = {m_sr[6:0], b};
            if (strobe) m_lat = m_sr;
        end
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; oe_n = 1'b0; strobe = 1'b1;
        step(1'b1);
        step(1'b1);
        check("R1", drv_out, 8'h00);
        check("R1", {7'd0, ser_out}, 8'h00);
        strobe = 1'b0; #0.5;
        check("R1", drv_out, 8'h00);
        rst_n = 1'b1;
    endtask

    task automatic t_load_and_strobe(input logic [7:0] pat);
        strobe = 1'b0; oe_n = 1'b0; #0.5;
        for (int i = 7; i >= 0; i--) begin
            step(pat[i]);
            check_all("R3");
            check("R5", drv_out, m_lat);
        end
        check("R2", m_sr, pat);
        strobe = 1'b1; #0.5;
        check("R4", drv_out, pat);
        step(pat[7]);
        check_all("R4");
        strobe = 1'b0; #0.5;
        check("R5", drv_out, {pat[6:0], pat[7]});
        for (int i = 0; i < 4; i++) begin
            step(~pat[i]);
            check("R5", drv_out, {pat[6:0], pat[7]});
        end
    endtask

    task automatic t_ripple();
        strobe = 1'b1; oe_n = 1'b0; #0.5;
        for (int i = 0; i < 8; i++) begin
            step(i[0] ^ i[1]);
            check_all("R4");
        end
        strobe = 1'b0; #0.5;
        check_all("R5");
    endtask

    task automatic t_enable(input logic [7:0] pat);
        oe_n = 1'b1; strobe = 1'b1; #0.5;
        for (int i = 7; i >= 0; i--) begin
            step(pat[i]);
            check("R7", drv_out, 8'h00);
        end
        strobe = 1'b0; #0.5;
        check("R7", drv_out, 8'h00);
        oe_n = 1'b0; #0.5;
        check("R6", drv_out, pat);
        oe_n = 1'b1; #0.5;
        check("R7", drv_out, 8'h00);
        oe_n = 1'b0; #0.5;
        check_all("R6");
    endtask

    task automatic t_serout_edges();
        strobe = 1'b0; #0.5;
        step(1'b1);
        for (int i = 0; i < 7; i++) step(1'b0);
        check("R3", {7'd0, ser_out}, 8'h01);
        ser_in = 1'b1; #1;
        check("R3", {7'd0, ser_out}, 8'h01);
        step(1'b1);
        check("R3", {7'd0, ser_out}, 8'h00);
    endtask

    task automatic t_reset_midrun();
        strobe = 1'b1; oe_n = 1'b0; #0.5;
        step(1'b1);
        strobe = 1'b0;
        rst_n = 1'b0;
        step(1'b1);
        check("R1", drv_out, 8'h00);
        check("R1", {7'd0, ser_out}, 8'h00);
        rst_n = 1'b1;
        strobe = 1'b1; #0.5;
        check("R1", drv_out, {7'd0, 1'b0});
        strobe = 1'b0;
    endtask

    initial begin
        @(posedge clk); #1;
        t_reset();
        t_load_and_strobe(8'hB4);
        t_load_and_strobe(8'h5A);
        t_load_and_strobe(8'($urandom));
        t_ripple();
        t_enable(8'hC3);
        t_enable(8'($urandom));
        t_serout_edges();
        t_reset_midrun();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule